// File: doc/BRIEF.md
# Real-Time Clock Core

This block keeps wall-clock time for a chip: a seconds counter and a milliseconds counter. Both advance from a slow tick enable, nominally at 32.768 kHz, that is sampled in the system clock domain. Milliseconds are formed with a fractional accumulator. Each tick adds the number of milliseconds per second, and a millisecond boundary is reached each time the sum passes the tick rate. This gives exactly one second of milliseconds per second of ticks, even though the tick rate is not a whole multiple of 1 kHz.

Software reaches the block through a flat register bus with an address, a write strobe, write data, a read strobe and combinational read data. The bus gives a coherent read of seconds and milliseconds: reading the milliseconds register captures the seconds into a shadow register, and the shadow is read next.

A busy flag marks one tick out of every eight. During that tick, writes to the time, alarm and mask registers are dropped. Two seconds alarms and one milliseconds alarm set sticky status bits. The status bits are cleared by writing 1 to them, and are combined with a mask into a single active-high interrupt.

Top module: `rtc_core`

## Requirements
- R1: Each tick adds MS_PER_SEC to an accumulator. When the sum reaches TICK_HZ, TICK_HZ is subtracted from it and the milliseconds counter advances. The milliseconds counter (read at byte offset 0x10) wraps from MS_PER_SEC-1 to 0, and on that wrap the 32-bit seconds counter (offset 0x08) increments, wrapping from all ones to 0.
- R2: Bit 0 of offset 0x04 reads 1 for exactly one tick interval out of every BUSY_PERIOD. After reset it reads 0 until BUSY_PERIOD-1 ticks have occurred, and it returns to 0 on the following tick.
- R3: A read strobe at offset 0x10 copies the seconds counter into the shadow register at offset 0x0C. A later shadow read returns the seconds value from the time of that milliseconds read, even after the seconds counter has moved on.
- R4: The seconds counter, seconds alarm 0 (offset 0x14) and seconds alarm 1 (offset 0x18) are 32 bits wide. A write stores its full value, and a read returns it. The milliseconds alarm (offset 0x1C) keeps the low bits of the written value, enough to hold a milliseconds count.
- R5: While busy reads 1, writes to the seconds, alarm and mask registers leave those registers unchanged. Reads are always served.
- R6: A seconds alarm sets its status bit when the seconds counter advances onto the alarm value. The milliseconds alarm does the same when the milliseconds counter advances onto its value. An alarm value of 0 never sets a bit. Status bit 0 is seconds alarm 0, bit 1 is seconds alarm 1, and bit 2 is the milliseconds alarm. Bits 3 and 4 exist but are never set.
- R7: Status (offset 0x2C) is sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged, whether or not busy is set. Writing all ones clears every bit.
- R8: The interrupt output is high exactly when some status bit is set whose matching bit in the mask register (offset 0x28, same bit layout) is also set.
- R9: Reset clears the counters, the shadow, all alarms, the mask and the status, and holds the interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable per slow-clock period |
| addr | input | 8 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (side effect: shadow capture) |
| rd_data | output | 32 | Combinational read data for addr |
| irq | output | 1 | Level-high masked interrupt |

## Verification
The hardest cases to reach are a write landing inside the single busy tick, and an alarm value of 0, which would need the seconds counter to wrap its full 32 bits. The bench runs a small configuration of 16 ticks per second and 4 ms per second. It steps tick by tick while tracking the busy phase arithmetically, so it can issue writes exactly inside and outside the busy tick. It loads the seconds counter to all ones so that the wrap to zero happens within a few ticks, with alarm 0 left at zero.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int TICK_HZ     = 32768,
  parameter int MS_PER_SEC  = 1000,
  parameter int BUSY_PERIOD = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [7:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        irq
);
  localparam int ACC_W = $clog2(TICK_HZ + MS_PER_SEC) + 1;
  localparam int MS_W  = $clog2(MS_PER_SEC);
  localparam int PH_W  = (BUSY_PERIOD > 1) ? $clog2(BUSY_PERIOD) : 1;
  localparam logic [7:0] A_BUSY = 8'h04, A_SEC = 8'h08, A_SHD = 8'h0C,
    A_MS = 8'h10, A_AL0 = 8'h14, A_AL1 = 8'h18, A_MAL = 8'h1C,
    A_MASK = 8'h28, A_STAT = 8'h2C;

  logic [ACC_W-1:0] acc_q;
  logic [MS_W-1:0]  ms_q, mal_q;
  logic [PH_W-1:0]  ph_q;
  logic [31:0]      sec_q, shd_q, al0_q, al1_q;
  logic [4:0]       mask_q, stat_q;

  logic [ACC_W-1:0] acc_sum;
  logic [MS_W-1:0]  ms_next;
  logic [31:0]      sec_inc;
  logic             busy, wr_ok, ms_step, ms_wrap, sec_wr;
  logic [4:0]       set_v, clr_v;

  assign busy    = (ph_q == PH_W'(BUSY_PERIOD - 1));
  assign wr_ok   = wr_en && !busy;
  assign sec_wr  = wr_ok && addr == A_SEC;
  assign acc_sum = acc_q + ACC_W'(MS_PER_SEC);
  assign ms_step = tick && (acc_sum >= ACC_W'(TICK_HZ));
  assign ms_wrap = ms_step && (ms_q == MS_W'(MS_PER_SEC - 1));
  assign ms_next = ms_wrap ? '0 : ms_q + 1'b1;
  assign sec_inc = sec_q + 32'd1;

  assign set_v[0] = ms_wrap && !sec_wr && al0_q != 0 && sec_inc == al0_q;
  assign set_v[1] = ms_wrap && !sec_wr && al1_q != 0 && sec_inc == al1_q;
  assign set_v[2] = ms_step && mal_q != 0 && ms_next == mal_q;
  assign set_v[4:3] = 2'b00;
  assign clr_v = (wr_en && addr == A_STAT) ? wr_data[4:0] : 5'd0;

  assign irq = |(stat_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; ms_q <= '0; ph_q <= '0; sec_q <= '0; shd_q <= '0;
      al0_q <= '0; al1_q <= '0; mal_q <= '0; mask_q <= '0; stat_q <= '0;
    end else begin
      if (tick) begin
        ph_q  <= busy ? '0 : ph_q + 1'b1;
        acc_q <= ms_step ? acc_sum - ACC_W'(TICK_HZ) : acc_sum;
      end
      if (ms_step) ms_q <= ms_next;
      if (sec_wr) sec_q <= wr_data;
      else if (ms_wrap) sec_q <= sec_inc;
      if (rd_en && addr == A_MS) shd_q <= sec_q;
      if (wr_ok && addr == A_AL0) al0_q <= wr_data;
      if (wr_ok && addr == A_AL1) al1_q <= wr_data;
      if (wr_ok && addr == A_MAL) mal_q <= wr_data[MS_W-1:0];
      if (wr_ok && addr == A_MASK) mask_q <= wr_data[4:0];
      stat_q <= (stat_q & ~clr_v) | set_v;
    end
  end

  always_comb begin
    case (addr)
      A_BUSY:  rd_data = {31'd0, busy};
      A_SEC:   rd_data = sec_q;
      A_SHD:   rd_data = shd_q;
      A_MS:    rd_data = 32'(ms_q);
      A_AL0:   rd_data = al0_q;
      A_AL1:   rd_data = al1_q;
      A_MAL:   rd_data = 32'(mal_q);
      A_MASK:  rd_data = {27'd0, mask_q};
      A_STAT:  rd_data = {27'd0, stat_q};
      default: rd_data = 32'd0;
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int MS_PER_SEC = 1000,
  parameter int MS_W       = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic [7:0]      addr,
  input logic            wr_en,
  input logic            rd_en,
  input logic            busy,
  input logic            irq,
  input logic [31:0]     sec,
  input logic [31:0]     shadow,
  input logic [MS_W-1:0] ms,
  input logic [4:0]      status,
  input logic [4:0]      mask
);
  AST_MS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ms) < MS_PER_SEC); // R1
  AST_BUSY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(busy)); // R2
  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'h10) |=> shadow == $past(sec)); // R3
  AST_BUSY_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == 8'h28) |=> $stable(mask)); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 8'h2C) |=> (status & $past(status)) == $past(status)); // R7
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 5'd0 && mask != 5'd0)); // R8
endmodule

bind rtc_core rtc_core_chk #(.MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
  .rd_en(rd_en), .busy(busy), .irq(irq), .sec(sec_q), .shadow(shd_q),
  .ms(ms_q), .status(stat_q), .mask(mask_q)
);

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 16, MSPS = 4, BP = 8;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_sec = 0, m_shd = 0, m_a0 = 0, m_a1 = 0;
  int m_ms = 0, m_acc = 0, m_ph = 0, m_mal = 0;
  logic [4:0] m_mask = 0, m_st = 0;

  rtc_core #(.TICK_HZ(HZ), .MS_PER_SEC(MSPS), .BUSY_PERIOD(BP)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    m_ph = (m_ph == BP - 1) ? 0 : m_ph + 1;
    m_acc += MSPS;
    if (m_acc >= HZ) begin
      m_acc -= HZ;
      if (m_ms == MSPS - 1) begin
        m_ms = 0;
        m_sec = m_sec + 1;
        if (m_a0 != 0 && m_sec == m_a0) m_st[0] = 1;
        if (m_a1 != 0 && m_sec == m_a1) m_st[1] = 1;
      end else m_ms++;
      if (m_mal != 0 && m_ms == m_mal) m_st[2] = 1;
    end
    tick = 1;
    @(posedge clk); @(negedge clk);
    tick = 0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    if (m_ph != BP - 1) begin
      case (a)
        8'h08: m_sec = d;
        8'h14: m_a0 = d;
        8'h18: m_a1 = d;
        8'h1C: m_mal = int'(d[1:0]);
        8'h28: m_mask = d[4:0];
        default: ;
      endcase
    end
    if (a == 8'h2C) m_st = m_st & ~d[4:0];
    addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    addr = a; rd_en = 1;
    #1 v = rd_data;
    @(posedge clk); @(negedge clk);
    rd_en = 0;
    if (a == 8'h10) m_shd = m_sec;
  endtask

  task automatic check_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic check_state(input string tag);
    check_reg({tag, " ms"}, 8'h10, 32'(m_ms));
    check_reg({tag, " shadow"}, 8'h0C, m_shd);
    check_reg({tag, " sec"}, 8'h08, m_sec);
    check_reg({tag, " busy"}, 8'h04, {31'd0, m_ph == BP - 1});
    check_reg({tag, " status"}, 8'h2C, {27'd0, m_st});
    check({tag, " irq"}, {31'd0, irq}, {31'd0, |(m_st & m_mask)});
  endtask

  task automatic to_idle();
    while (m_ph == BP - 1) do_tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 irq in reset", {31'd0, irq}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check_state("R9 reset");
    check_reg("R9 mask reset", 8'h28, 32'd0);
    check_reg("R9 alarm0 reset", 8'h14, 32'd0);
    check_reg("R9 malarm reset", 8'h1C, 32'd0);

    // R1 R2 R3: sweep across several seconds
    for (int i = 0; i < 100; i++) begin
      do_tick();
      check_state("R1 R2 R3 sweep");
    end

    // R3: shadow holds capture time while seconds move on
    begin
      logic [31:0] snap;
      bus_read(8'h10, snap);
      snap = m_shd;
      repeat (20) do_tick();
      check_reg("R3 shadow held", 8'h0C, snap);
    end

    // R4: full-width writes
    to_idle();
    bus_write(8'h14, 32'hA5C3_0F01);
    check_reg("R4 alarm0 width", 8'h14, 32'hA5C3_0F01);
    to_idle();
    bus_write(8'h18, 32'h8000_0001);
    check_reg("R4 alarm1 width", 8'h18, 32'h8000_0001);
    to_idle();
    bus_write(8'h08, 32'hDEAD_BEEF);
    check_reg("R4 sec width", 8'h08, 32'hDEAD_BEEF);

    // R5: writes inside busy tick dropped
    while (m_ph != BP - 1) do_tick();
    bus_write(8'h08, 32'h1234);
    check_reg("R5 sec busy write", 8'h08, m_sec);
    check_reg("R5 busy still", 8'h04, 32'd1);
    bus_write(8'h28, 32'h1F);
    check_reg("R5 mask busy write", 8'h28, {27'd0, m_mask});
    bus_write(8'h14, 32'h77);
    check_reg("R5 alarm busy write", 8'h14, m_a0);
    do_tick();
    bus_write(8'h08, 32'h1234);
    check_reg("R5 sec idle write", 8'h08, 32'h1234);

    // R6 R8: seconds alarm 0 masked in
    to_idle(); bus_write(8'h14, m_sec + 2);
    to_idle(); bus_write(8'h18, 32'd0);
    to_idle(); bus_write(8'h28, 32'h01);
    for (int i = 0; i < 40; i++) begin do_tick(); check_state("R6 R8 alarm0"); end
    check("R6 alarm0 fired", {31'd0, m_st[0]}, 32'd1);

    // R7: write 0 keeps, write 1 clears
    bus_write(8'h2C, 32'h0);
    check_state("R7 w0 keeps");
    bus_write(8'h2C, 32'h1);
    check_state("R7 w1 clears");

    // R6 R8: alarm1 unmasked, then masked in
    to_idle(); bus_write(8'h18, m_sec + 1);
    to_idle(); bus_write(8'h28, 32'h0);
    for (int i = 0; i < 20; i++) begin do_tick(); check_state("R6 R8 alarm1 unmasked"); end
    to_idle(); bus_write(8'h28, 32'h02);
    check_state("R8 alarm1 masked");

    // R6: millisecond alarm
    to_idle(); bus_write(8'h1C, 32'd2);
    to_idle(); bus_write(8'h28, 32'h04);
    for (int i = 0; i < 20; i++) begin do_tick(); check_state("R6 ms alarm"); end

    // R7: all ones clears all (even during busy)
    while (m_ph != BP - 1) do_tick();
    bus_write(8'h2C, 32'hFFFF_FFFF);
    check_state("R7 clear all");

    // R1 R6: 32-bit wrap with alarm value 0
    to_idle(); bus_write(8'h1C, 32'd0);
    to_idle(); bus_write(8'h14, 32'd0);
    to_idle(); bus_write(8'h18, 32'd0);
    to_idle(); bus_write(8'h28, 32'h1F);
    to_idle(); bus_write(8'h08, 32'hFFFF_FFFF);
    for (int i = 0; i < 40; i++) begin do_tick(); check_state("R1 R6 zero alarm wrap"); end
    check("R1 wrapped", {31'd0, m_sec < 32'd4}, 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule